// File: doc/BRIEF.md
# Register-Mapped Single-Channel PWM Controller

This block is a small PWM peripheral that sits on a byte-wide, single-cycle bus slave port. Software programs an 8-bit duty value, a 16-bit prescaler reload value split over two byte registers, and a control/status register. The prescaler counts down on every clock. Each time it passes zero it reloads and emits a tick. An 8-bit PWM counter steps down once per tick. The PWM output is high while that counter is below the duty value, so 00h is always off and FFh is always on.

Two sticky overflow flags record prescaler and PWM counter underflows. They are set whether or not their interrupt enables are on, so software can poll them. Software clears a flag by writing 0 to its bit. A single level interrupt combines the flags with per-source enables and a global enable.

When the controller enable is 0, both outputs are held low and no flag is set. The prescaler keeps counting down but does not reload: it wraps through all-ones instead. After the block is re-enabled, the first tick can therefore arrive up to 2^16 cycles later.

Top module: `pwm8_regbus`

## Requirements
- R1: Four byte registers, all readable and writable and all 00h after reset: address 0 holds the duty value, address 1 the reload low byte, address 2 the reload high byte, address 3 the control register. Control bits, from 7 down to 0: PWM-counter flag, prescaler flag, spare 1, spare 0, PWM-counter interrupt enable, prescaler interrupt enable, global interrupt enable, controller enable.
- R2: A bus access with cycle and strobe high gets an acknowledge exactly one cycle later. The acknowledge lasts one cycle. Write data takes effect on the acknowledging edge, and read data is valid while the acknowledge is high.
- R3: With a tick on every clock, the PWM output is high for exactly D of every 256 cycles for a duty D of 0 to 254, and high in all 256 cycles for D = FFh.
- R4: While enabled, the prescaler reloads from {high, low} on underflow. Ticks, seen as one-cycle pulses on tick_o, are spaced reload+1 cycles apart.
- R5: The PWM counter steps once per tick, so the PWM period is 256*(reload+1) cycles. Over that period the output is high for D*(reload+1) cycles.
- R6: The prescaler flag (bit 6) is set on each enabled prescaler underflow. The PWM-counter flag (bit 7) is set when the PWM counter steps past zero. Both are set even when their interrupt enables are 0.
- R7: Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R8: irq_o, registered, equals global enable AND ((bit 7 AND bit 3) OR (bit 6 AND bit 2)) as of the previous cycle.
- R9: With the controller enable at 0, pwm_o and tick_o are low and neither flag is set.
- R10: With the controller enable at 0, the prescaler keeps counting down and wraps from 0 to all-ones without reloading.
- R11: The spare bits 5 and 4 are plain storage with no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cyc_i | input | 1 | Bus cycle valid |
| bus_stb_i | input | 1 | Bus strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_adr_i | input | 2 | Register address |
| bus_dat_i | input | DW (8) | Write data |
| bus_dat_o | output | DW (8) | Read data, valid with acknowledge |
| bus_ack_o | output | 1 | Access acknowledge |
| pwm_o | output | 1 | PWM waveform |
| tick_o | output | 1 | Registered prescaler underflow pulse, gated by the enable |
| irq_o | output | 1 | Level interrupt request |

## Verification
The checker watches several behaviours on every clock:
- the acknowledge timing;
- the reload-versus-wrap choice the prescaler makes at zero, depending on the enable;
- flag persistence, and the set-wins priority;
- the interrupt equation;
- forced-low outputs while disabled;
- the constant outputs at duty 00h and FFh.

Only the bench scenarios can show the arithmetic results:
- the exact high count for every duty value;
- the measured tick spacing for several reload values;
- the PWM period scaling with the prescaler;
- the long wait before the first tick after enabling.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  localparam logic [1:0] ADR_DUTY = 2'd0;
  localparam logic [1:0] ADR_RLO  = 2'd1;
  localparam logic [1:0] ADR_RHI  = 2'd2;
  localparam logic [1:0] ADR_CTRL = 2'd3;

  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_GIE   = 1;
  localparam int unsigned CB_PIE   = 2;
  localparam int unsigned CB_CIE   = 3;
  localparam int unsigned CB_PFLAG = 6;
  localparam int unsigned CB_CFLAG = 7;
  localparam int unsigned MISC_W   = 6;
endpackage

// File: rtl/pwm8_presc.sv
module pwm8_presc #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         uf_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    uf_o  = (cnt_q == '0);
    cnt_d = (uf_o && en_i) ? reload_i : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm8_wave.sv
module pwm8_wave #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [DW-1:0] duty_i,
  output logic          pwm_o,
  output logic          aux_o,
  output logic          wrap_o
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          pwm_q, pwm_d, aux_q, aux_d;

  always_comb begin
    cnt_d  = cnt_q - DW'(1);
    wrap_o = en_i & tick_i & (cnt_q == '0);
    pwm_d  = en_i & ((duty_i == '1) | (cnt_q < duty_i));
    aux_d  = en_i & tick_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
      aux_q <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= cnt_d;
      pwm_q <= pwm_d;
      aux_q <= aux_d;
    end
  end

  assign pwm_o = pwm_q;
  assign aux_o = aux_q;
endmodule

// File: rtl/pwm8_regs.sv
module pwm8_regs
  import pwm8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_i,
  input  logic            stb_i,
  input  logic            we_i,
  input  logic [1:0]      adr_i,
  input  logic [DW-1:0]   dat_i,
  output logic [DW-1:0]   dat_o,
  output logic            ack_o,
  input  logic            pre_evt_i,
  input  logic            cyc_evt_i,
  output logic [DW-1:0]   duty_o,
  output logic [2*DW-1:0] reload_o,
  output logic [7:0]      ctrl_o,
  output logic            irq_o
);
  logic [DW-1:0]     duty_q, duty_d, rlo_q, rlo_d, rhi_q, rhi_d, rd_q, rd_d;
  logic [MISC_W-1:0] misc_q, misc_d;
  logic              cflag_q, cflag_d, pflag_q, pflag_d;
  logic              ack_q, irq_q, irq_d;
  logic              acc, wr, clr_c, clr_p;
  logic [7:0]        ctrl;

  always_comb begin
    acc    = cyc_i & stb_i & ~ack_q;
    wr     = acc & we_i;
    duty_d = duty_q;
    rlo_d  = rlo_q;
    rhi_d  = rhi_q;
    misc_d = misc_q;
    if (wr) begin
      case (adr_i)
        ADR_DUTY: duty_d = dat_i;
        ADR_RLO:  rlo_d  = dat_i;
        ADR_RHI:  rhi_d  = dat_i;
        default:  misc_d = dat_i[MISC_W-1:0];
      endcase
    end
    clr_c   = wr && (adr_i == ADR_CTRL) && !dat_i[CB_CFLAG];
    clr_p   = wr && (adr_i == ADR_CTRL) && !dat_i[CB_PFLAG];
    cflag_d = cyc_evt_i | (cflag_q & ~clr_c);
    pflag_d = pre_evt_i | (pflag_q & ~clr_p);
    ctrl    = {cflag_q, pflag_q, misc_q};
    irq_d   = ctrl[CB_GIE] & ((ctrl[CB_CFLAG] & ctrl[CB_CIE]) |
                              (ctrl[CB_PFLAG] & ctrl[CB_PIE]));
    case (adr_i)
      ADR_DUTY: rd_d = duty_q;
      ADR_RLO:  rd_d = rlo_q;
      ADR_RHI:  rd_d = rhi_q;
      default:  rd_d = DW'(ctrl);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q  <= '0;
      rlo_q   <= '0;
      rhi_q   <= '0;
      misc_q  <= '0;
      cflag_q <= 1'b0;
      pflag_q <= 1'b0;
      ack_q   <= 1'b0;
      irq_q   <= 1'b0;
      rd_q    <= '0;
    end else begin
      if (wr) begin
        duty_q <= duty_d;
        rlo_q  <= rlo_d;
        rhi_q  <= rhi_d;
        misc_q <= misc_d;
      end
      if (acc && !we_i) rd_q <= rd_d;
      cflag_q <= cflag_d;
      pflag_q <= pflag_d;
      ack_q   <= acc;
      irq_q   <= irq_d;
    end
  end

  assign dat_o    = rd_q;
  assign ack_o    = ack_q;
  assign duty_o   = duty_q;
  assign reload_o = {rhi_q, rlo_q};
  assign ctrl_o   = ctrl;
  assign irq_o    = irq_q;
endmodule

// File: rtl/pwm8_regbus.sv
module pwm8_regbus
  import pwm8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cyc_i,
  input  logic          bus_stb_i,
  input  logic          bus_we_i,
  input  logic [1:0]    bus_adr_i,
  input  logic [DW-1:0] bus_dat_i,
  output logic [DW-1:0] bus_dat_o,
  output logic          bus_ack_o,
  output logic          pwm_o,
  output logic          tick_o,
  output logic          irq_o
);
  localparam int unsigned PW = 2 * DW;

  logic [1:0]    rs_q;
  logic          rst_n_int;
  logic [DW-1:0] duty_w;
  logic [PW-1:0] reload_w, pre_cnt_w;
  logic [7:0]    ctrl_w;
  logic          en, pre_uf, pre_evt, cyc_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_int = rs_q[1];

  assign en      = ctrl_w[CB_EN];
  assign pre_evt = en & pre_uf;

  pwm8_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n_int),
    .cyc_i(bus_cyc_i), .stb_i(bus_stb_i), .we_i(bus_we_i),
    .adr_i(bus_adr_i), .dat_i(bus_dat_i), .dat_o(bus_dat_o), .ack_o(bus_ack_o),
    .pre_evt_i(pre_evt), .cyc_evt_i(cyc_evt),
    .duty_o(duty_w), .reload_o(reload_w), .ctrl_o(ctrl_w), .irq_o(irq_o)
  );

  pwm8_presc #(.W(PW)) u_presc (
    .clk(clk), .rst_n(rst_n_int), .en_i(en), .reload_i(reload_w),
    .cnt_o(pre_cnt_w), .uf_o(pre_uf)
  );

  pwm8_wave #(.DW(DW)) u_wave (
    .clk(clk), .rst_n(rst_n_int), .en_i(en), .tick_i(pre_uf),
    .duty_i(duty_w), .pwm_o(pwm_o), .aux_o(tick_o), .wrap_o(cyc_evt)
  );
endmodule

// File: rtl/pwm8_chk.sv
module pwm8_chk #(
  parameter int unsigned DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cyc,
  input logic            stb,
  input logic            we,
  input logic [1:0]      adr,
  input logic            wd7,
  input logic            wd6,
  input logic            ack,
  input logic            pwm,
  input logic            tick,
  input logic            irq,
  input logic [7:0]      ctrl,
  input logic [DW-1:0]   duty,
  input logic [2*DW-1:0] reload,
  input logic [2*DW-1:0] pre_cnt
);
  logic wr_ctrl;
  assign wr_ctrl = cyc && stb && we && !ack && (adr == 2'd3);

  assert_ack_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && stb && !ack) |=> ack);
  assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_full_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && duty == '1) |=> pwm);
  assert_zero_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |=> !pwm);
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && pre_cnt == '0) |=> (pre_cnt == $past(reload)));
  assert_pre_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && pre_cnt == '0) |=> ctrl[6]);
  assert_cflag_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[7] && !(wr_ctrl && !wd7)) |=> ctrl[7]);
  assert_pflag_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] && !(wr_ctrl && !wd6)) |=> ctrl[6]);
  assert_irq_eq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(ctrl[1] && ((ctrl[7] && ctrl[3]) || (ctrl[6] && ctrl[2]))));
  assert_quiet_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |=> (!pwm && !tick));
  assert_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !ctrl[7] && !ctrl[6]) |=> (!ctrl[7] && !ctrl[6]));
  assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && pre_cnt == '0) |=> (pre_cnt == '1));
endmodule

bind pwm8_regbus pwm8_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n_int), .cyc(bus_cyc_i), .stb(bus_stb_i), .we(bus_we_i),
  .adr(bus_adr_i), .wd7(bus_dat_i[7]), .wd6(bus_dat_i[6]), .ack(bus_ack_o),
  .pwm(pwm_o), .tick(tick_o), .irq(irq_o), .ctrl(ctrl_w), .duty(duty_w),
  .reload(reload_w), .pre_cnt(pre_cnt_w)
);

// File: tb/test_pwm8_regbus.sv
`timescale 1ns/1ps
module test_pwm8_regbus;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [1:0] adr = '0;
  logic [7:0] wdat = '0;
  logic [7:0] rdat;
  logic       ack, pwm, tick, irq;
  int         checks = 0;
  int         fails = 0;

  always #4 clk = ~clk;

  pwm8_regbus i_pwm8_regbus (
    .clk(clk), .rst_n(rst_n), .bus_cyc_i(cyc), .bus_stb_i(stb), .bus_we_i(we),
    .bus_adr_i(adr), .bus_dat_i(wdat), .bus_dat_o(rdat), .bus_ack_o(ack),
    .pwm_o(pwm), .tick_o(tick), .irq_o(irq)
  );

  task automatic check_in(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=[%0d..%0d]", req, act, lo, hi);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic bus_acc(input logic w, input logic [1:0] a, input logic [7:0] d,
                         output logic [7:0] q);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
    @(negedge clk);
    check_in("R2 ack", int'(ack), 1, 1);
    q = rdat;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(negedge clk);
    check_in("R2 ack drop", int'(ack), 0, 0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] q;
    bus_acc(1'b1, a, d, q);
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input int exp);
    logic [7:0] q;
    bus_acc(1'b0, a, 8'h00, q);
    check_in(req, int'(q), exp, exp);
  endtask

  task automatic wait_tick_rise();
    do @(negedge clk); while (tick);
    do @(negedge clk); while (!tick);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n, hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset values
    check_in("R1 pwm reset", int'(pwm), 0, 0);
    check_in("R1 irq reset", int'(irq), 0, 0);
    for (int a = 0; a < 4; a++) rd_chk("R1 reset value", 2'(a), 0);
    // R1 / R11 read-write
    wr(2'd0, 8'hA5); wr(2'd1, 8'h5A); wr(2'd2, 8'hC3); wr(2'd3, 8'h3C);
    rd_chk("R1 duty rw", 2'd0, 'hA5);
    rd_chk("R1 rlo rw", 2'd1, 'h5A);
    rd_chk("R1 rhi rw", 2'd2, 'hC3);
    rd_chk("R11 spare rw", 2'd3, 'h3C);
    wr(2'd3, 8'h10);
    rd_chk("R11 spare single", 2'd3, 'h10);
    wr(2'd3, 8'h30); wr(2'd0, 8'h80); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    // R9 disabled: outputs low, no flags
    hi = 0;
    repeat (300) begin @(negedge clk); hi += int'(pwm) + int'(tick); end
    check_in("R9 outputs low", hi, 0, 0);
    rd_chk("R9 no flags", 2'd3, 'h30);
    // R10 prescaler wrapped while disabled: first tick far away
    wr(2'd3, 8'h01);
    n = 0;
    while (!tick && n < 70000) begin @(negedge clk); n++; end
    check_in("R10 wrap delay", n, 60000, 66000);
    // R3 full duty sweep, reload 0
    for (int d = 0; d < 256; d++) begin
      wr(2'd0, 8'(d));
      repeat (3) @(negedge clk);
      hi = 0;
      repeat (256) begin @(negedge clk); hi += int'(pwm); end
      check_in("R3 duty", hi, (d == 255) ? 256 : d, (d == 255) ? 256 : d);
    end
    // R4 tick spacing
    wr(2'd1, 8'd5);
    wait_tick_rise();
    n = 0; do begin @(negedge clk); n++; end while (!tick);
    check_in("R4 spacing 5", n, 6, 6);
    wr(2'd2, 8'h01); wr(2'd1, 8'h02);
    wait_tick_rise();
    n = 0; do begin @(negedge clk); n++; end while (!tick);
    check_in("R4 spacing 0x0102", n, 259, 259);
    // R5 PWM period with prescaler
    wr(2'd2, 8'h00); wr(2'd1, 8'd3); wr(2'd0, 8'h40);
    wait_tick_rise();
    hi = 0; n = 0;
    repeat (1024) begin @(negedge clk); hi += int'(pwm); n += int'(tick); end
    check_in("R5 high cycles", hi, 256, 256);
    check_in("R5 ticks per period", n, 256, 256);
    // R6 flags set with interrupt enables off
    wr(2'd1, 8'd0);
    wr(2'd3, 8'h01);
    repeat (300) @(negedge clk);
    rd_chk("R6 both flags", 2'd3, 'hC1);
    check_in("R6 irq masked", int'(irq), 0, 0);
    // R7 clear by zero, keep by one
    wr(2'd2, 8'h10);
    wait_tick_rise();
    wr(2'd3, 8'hC1);
    rd_chk("R7 write one keeps", 2'd3, 'hC1);
    wr(2'd3, 8'h81);
    rd_chk("R7 clear prescaler flag", 2'd3, 'h81);
    wr(2'd3, 8'h01);
    rd_chk("R7 clear pwm flag", 2'd3, 'h01);
    // R8 interrupt combine
    wr(2'd3, 8'h07);
    repeat (2) @(negedge clk);
    check_in("R8 irq idle", int'(irq), 0, 0);
    wait_tick_rise();
    repeat (3) @(negedge clk);
    check_in("R8 irq on flag", int'(irq), 1, 1);
    wr(2'd3, 8'h45);
    repeat (2) @(negedge clk);
    check_in("R8 irq global off", int'(irq), 0, 0);
    rd_chk("R8 flag kept", 2'd3, 'h45);
    finish_run();
  end
endmodule